// File: doc/BRIEF.md
# Multi-Source XOR Copy Datapath

This block carries out a single already-decoded transfer descriptor. It takes a 32-bit control word and a byte count. It then reads beat streams from up to eight source buffers and emits one destination beat stream. Each stream uses a valid/ready handshake.

The block supports three operations:

- A copy forwards source 0 unchanged.
- A parity operation XORs the same-numbered beat of every active source.
- A no-op moves no data and only reports that it has finished.

Any other operation code, or a parity request with a bad source count, finishes at once with an error flag and produces no output.

A descriptor is accepted by pulsing `start` while `busy` is low. Completion is reported by a one-cycle `done` pulse. `done_irq` copies the descriptor's interrupt-request bit and `done_err` marks a rejected descriptor. Addressing, the system bus and the remaining descriptor modes are handled elsewhere.

Top module: `xor_stripe_engine`

## Requirements
- R1: After reset `busy`, `dst_valid`, `done`, `done_irq`, `done_err` and every `src_ready` bit are low.
- R2: Operation code 1 (control bits [31:28]) copies source 0 to the destination beat for beat. Sources 1 to 7 see `src_ready` low and their data has no effect.
- R3: Operation code 6 XORs the same-index beats of sources 0 to N-1. N is the count in control bits [25:22]. Sources at index N or above see `src_ready` low and their data has no effect on the output.
- R4: A copy or parity descriptor emits ceil(length/4) beats, with `dst_last` high on the final beat only. A length of 0 emits no beat and still completes without error.
- R5: `dst_keep` is 4'b1111 on every beat except the last. On the last beat, when length mod 4 is a nonzero value r, it holds the low r bits set.
- R6: `dst_valid` is high only when every active source has a valid beat. No source beat is consumed in a cycle where `dst_ready` is low.
- R7: Operation code 0 produces no output beat. `done` is high in the cycle after the accepting edge.
- R8: A parity descriptor with count 0, count above 8, or control bit 17 clear ends with `done` and `done_err` high and no output. So does any operation code other than 0, 1 or 6.
- R9: At every `done` pulse, `done_irq` equals control bit 27 of the finished descriptor. For a completed transfer, `done` rises in the cycle after the last beat's handshake.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Descriptor strobe, taken when not busy |
| ctrl | input | 32 | Control word: op [31:28], irq 27, count [25:22], parity enable 17 |
| byte_len | input | LEN_W | Bytes to process per source |
| busy | output | 1 | Transfer in progress |
| src_valid | input | NSRC | Per-source beat valid |
| src_data | input | NSRC*BEAT_W | Source beats, source i in slice i |
| src_ready | output | NSRC | Per-source beat accept |
| dst_valid | output | 1 | Destination beat valid |
| dst_data | output | BEAT_W | Destination beat |
| dst_keep | output | BEAT_W/8 | Byte enables of the destination beat |
| dst_last | output | 1 | Final destination beat |
| dst_ready | input | 1 | Destination accepts beat |
| done | output | 1 | One-cycle completion pulse |
| done_irq | output | 1 | Completion requested an interrupt |
| done_err | output | 1 | Descriptor rejected |

## Verification
The hardest case to reach is a parity transfer in which the active sources deliver beats at different times while the destination also applies backpressure. In that case one source may sit valid for many cycles waiting on another, and no beat may be taken early. The stimulus toggles each source's valid and the destination ready at random every cycle, with a different ready probability per descriptor. Idle sources above the active count always carry random data and random valids, so any leak of their data into the output or any early `src_ready` is caught.

// File: rtl/xor_stripe_engine.sv
`timescale 1ns/1ps
module xor_stripe_engine #(
  parameter int NSRC   = 8,
  parameter int BEAT_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [31:0]            ctrl,
  input  logic [LEN_W-1:0]       byte_len,
  output logic                   busy,
  input  logic [NSRC-1:0]        src_valid,
  input  logic [NSRC*BEAT_W-1:0] src_data,
  output logic [NSRC-1:0]        src_ready,
  output logic                   dst_valid,
  output logic [BEAT_W-1:0]      dst_data,
  output logic [BEAT_W/8-1:0]    dst_keep,
  output logic                   dst_last,
  input  logic                   dst_ready,
  output logic                   done,
  output logic                   done_irq,
  output logic                   done_err
);
  localparam int BYTES = BEAT_W / 8;
  localparam int BSH   = $clog2(BYTES);

  logic [3:0]       op, cnt;
  logic             is_nop, is_cpy, is_xor, bad;
  logic [LEN_W:0]   beats_in;
  logic [NSRC-1:0]  new_mask, mask;
  logic             run, hdr_irq, all_v, fire;
  logic [LEN_W-1:0] rem;
  logic [BSH-1:0]   tail;

  assign op       = ctrl[31:28];
  assign cnt      = ctrl[25:22];
  assign is_nop   = op == 4'd0;
  assign is_cpy   = op == 4'd1;
  assign is_xor   = op == 4'd6;
  assign bad      = !(is_nop || is_cpy || is_xor) ||
                    (is_xor && (cnt == 4'd0 || 32'(cnt) > NSRC || !ctrl[17]));
  assign beats_in = ({1'b0, byte_len} + (LEN_W+1)'(BYTES - 1)) >> BSH;

  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    assign new_mask[i] = is_cpy ? (i == 0) : (32'(cnt) > i);
  end

  assign busy      = run;
  assign all_v     = &(src_valid | ~mask);
  assign dst_valid = run && all_v;
  assign fire      = dst_valid && dst_ready;
  assign src_ready = {NSRC{fire}} & mask;
  assign dst_last  = rem == LEN_W'(1);

  always_comb begin
    dst_data = '0;
    for (int i = 0; i < NSRC; i++)
      if (mask[i]) dst_data = dst_data ^ src_data[i*BEAT_W +: BEAT_W];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_keep
    assign dst_keep[b] = !dst_last || tail == '0 || 32'(tail) > b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; hdr_irq <= 1'b0; mask <= '0; rem <= '0; tail <= '0;
      done <= 1'b0; done_irq <= 1'b0; done_err <= 1'b0;
    end else begin
      done <= 1'b0; done_irq <= 1'b0; done_err <= 1'b0;
      if (!run && start) begin
        hdr_irq <= ctrl[27];
        mask    <= new_mask;
        tail    <= byte_len[BSH-1:0];
        rem     <= beats_in[LEN_W-1:0];
        if (bad || is_nop || beats_in == '0) begin
          done <= 1'b1; done_irq <= ctrl[27]; done_err <= bad;
        end else begin
          run <= 1'b1;
        end
      end else if (fire) begin
        rem <= rem - LEN_W'(1);
        if (dst_last) begin
          run <= 1'b0; done <= 1'b1; done_irq <= hdr_irq;
        end
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dst_valid && src_ready == '0));
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |-> src_ready == '0);
  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready && dst_last) |=> (done && !busy));
  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> (done && !busy));
  // R10
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/xor_stripe_engine_tb_top.sv
`timescale 1ns/1ps
module xor_stripe_engine_tb_top;
  localparam int NSRC = 8;

  logic clk = 0, rst_n = 0, start = 0, dst_ready = 0;
  logic [31:0] ctrl = '0;
  logic [15:0] byte_len = '0;
  logic [NSRC-1:0] src_valid = '0, src_ready;
  logic [NSRC*32-1:0] src_data = '0;
  logic busy, dst_valid, dst_last, done, done_irq, done_err;
  logic [31:0] dst_data;
  logic [3:0] dst_keep;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xor_stripe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .byte_len(byte_len),
    .busy(busy), .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .dst_valid(dst_valid), .dst_data(dst_data), .dst_keep(dst_keep),
    .dst_last(dst_last), .dst_ready(dst_ready), .done(done),
    .done_irq(done_irq), .done_err(done_err));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] s, input int i, input int k);
    return s ^ (32'(i) * 32'h01000193) ^ (32'(k) * 32'h2545F491) ^ {8'(i), 24'h0};
  endfunction

  function automatic logic [31:0] exp_beat(input logic [31:0] s, input int n, input int k);
    logic [31:0] a = '0;
    for (int i = 0; i < n; i++) a ^= pat(s, i, k);
    return a;
  endfunction

  function automatic logic [3:0] exp_keep(input int len, input bit last);
    if (!last || (len % 4) == 0) return 4'hF;
    return 4'((1 << (len % 4)) - 1);
  endfunction

  task automatic run_desc(input logic [31:0] c, input int len, input int bp,
                          input bit exp_err, input string req, input bit poke);
    int op = int'(c[31:28]);
    int n = (op == 1) ? 1 : (op == 6 ? int'(c[25:22]) : 0);
    int exp_b = (!exp_err && (op == 1 || op == 6)) ? (len + 3) / 4 : 0;
    logic [31:0] ds = $urandom;
    int ptr[NSRC];
    int got = 0, cyc = 0;
    bit ign_ok = 1, stall_ok = 1, data_ok = 1;
    for (int i = 0; i < NSRC; i++) ptr[i] = 0;
    @(negedge clk);
    start = 1; ctrl = c; byte_len = 16'(len);
    forever begin
      @(negedge clk);
      start = (poke && cyc == 0);
      if (poke && cyc == 0) ctrl = 32'h0800_0000;
      if (done) break;
      if (cyc > 20000) begin
        check(0, "R9 completion timeout", cyc, 0);
        break;
      end
      for (int i = 0; i < NSRC; i++) begin
        src_valid[i] = ($urandom % 100) < 70;
        src_data[i*32 +: 32] = (i < n) ? pat(ds, i, ptr[i]) : $urandom;
      end
      dst_ready = ($urandom % 100) < bp;
      #1;
      if (dst_valid && dst_ready) begin
        if (got >= exp_b || dst_data !== exp_beat(ds, n, got) ||
            dst_keep !== exp_keep(len, got == exp_b - 1) || dst_last !== (got == exp_b - 1)) begin
          if (data_ok)
            check(0, {req, " R4 R5 beat data/keep/last"}, {dst_last, dst_keep, dst_data},
                  {1'(got == exp_b - 1), exp_keep(len, got == exp_b - 1), exp_beat(ds, n, got)});
          data_ok = 0;
        end
        got++;
      end
      if (dst_valid)
        for (int i = 0; i < n; i++) if (!src_valid[i]) stall_ok = 0;
      if (!dst_ready && src_ready != '0) stall_ok = 0;
      for (int i = 0; i < NSRC; i++) begin
        if (src_ready[i] && i >= n) ign_ok = 0;
        if (src_ready[i] && src_valid[i]) ptr[i]++;
      end
      cyc++;
    end
    if (data_ok) check(1, req, 0, 0);
    check(got == exp_b, {req, " R4 beat count"}, got, exp_b);
    check(ign_ok, {req, " R2 R3 inactive source ready"}, 0, 1);
    check(stall_ok, {req, " R6 stall rule"}, 0, 1);
    check(done_irq == c[27], {req, " R9 irq flag"}, done_irq, c[27]);
    check(done_err == exp_err, {req, " R8 error flag"}, done_err, exp_err);
    if (op == 0 || exp_err) check(cyc == 0, {req, " R7 R8 done next cycle"}, cyc, 0);
    src_valid = '0; dst_ready = 0;
  endtask

  function automatic logic [31:0] mk(input int op, input int cnt, input bit irq, input bit pen);
    return {4'(op), 1'b0 | irq, 1'b0, 4'(cnt), 4'h0, 1'b0 | pen, 17'h0} & 32'hFFFF_FFFF;
  endfunction

  initial begin
    #1_500_000;
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !dst_valid && !done && !done_irq && !done_err && src_ready == '0,
          "R1 reset state", {busy, dst_valid, done, src_ready}, 0);

    run_desc(mk(0, 0, 1, 0), 0, 90, 0, "R7 nop irq", 0);
    run_desc(mk(0, 3, 0, 0), 40, 90, 0, "R7 nop quiet", 0);
    run_desc(mk(6, 0, 1, 1), 16, 90, 1, "R8 count zero", 0);
    run_desc(mk(6, 9, 1, 1), 16, 90, 1, "R8 count nine", 0);
    run_desc(mk(6, 15, 0, 1), 16, 90, 1, "R8 count fifteen", 0);
    run_desc(mk(6, 4, 1, 0), 16, 90, 1, "R8 parity enable clear", 0);
    run_desc(mk(2, 1, 1, 1), 16, 90, 1, "R8 op2", 0);
    run_desc(mk(5, 1, 0, 1), 16, 90, 1, "R8 op5", 0);
    run_desc(mk(7, 2, 1, 1), 16, 90, 1, "R8 op7", 0);
    run_desc(mk(8, 2, 1, 1), 16, 90, 1, "R8 op8", 0);
    run_desc(mk(15, 2, 0, 1), 16, 90, 1, "R8 op15", 0);
    run_desc(mk(1, 0, 1, 0), 0, 90, 0, "R4 copy len0", 0);
    run_desc(mk(1, 5, 1, 0), 4, 100, 0, "R2 copy one beat", 0);
    run_desc(mk(1, 0, 0, 0), 7, 50, 0, "R5 copy tail3", 0);
    run_desc(mk(6, 8, 1, 1), 33, 20, 0, "R3 R6 xor8 heavy stall", 0);
    run_desc(mk(6, 1, 0, 1), 10, 80, 0, "R3 xor1", 0);
    run_desc(mk(6, 3, 1, 1), 24, 70, 0, "R10 start while busy", 1);
    for (int t = 0; t < 40; t++)
      run_desc(mk(6, 1 + $urandom % 8, $urandom % 2, 1), 1 + $urandom % 64,
               10 + $urandom % 91, 0, "R3 random xor", 0);
    for (int t = 0; t < 15; t++)
      run_desc(mk(1, $urandom % 16, $urandom % 2, $urandom % 2), 1 + $urandom % 64,
               10 + $urandom % 91, 0, "R2 random copy", 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule